// File: doc/BRIEF.md
# Configuration Image Clock Ratio Detector

This block watches the leading words of a 32-bit configuration image as they stream past. Two fixed header words carry the image's properties. One holds an encryption mode field and the other holds a compression flag. The block latches the encryption indication when its word goes by. When the compression word arrives, it combines both indications with the selected configuration width (16 or 32 bit) into a 2-bit, log-encoded clock-to-data ratio code. That code is what the configuration interface has to be programmed with before data streaming starts.

A start-of-image pulse restarts the word count and clears every result. The result is registered and held until the next start pulse. An end-of-image pulse that comes before the compression word has been taken marks the header as too short. The block only observes the stream: it never stalls it, and the data is not altered or transferred by it.

Top module: `cfg_hdr_ratio_detect`

## Requirements
- R1: After reset `ratio_vld_o`, `short_err_o` and `ratio_o` are all 0, and the next accepted word is header word 0.
- R2: A cycle with `sof_i` high restarts the image. The word accepted in that same cycle (if any) is word 0. From the following cycle `ratio_vld_o` and `short_err_o` are 0, and any earlier encryption indication is discarded.
- R3: The image is taken as encrypted when bits [3:2] of header word 69 are not both zero. Word 69 of an earlier image has no effect after a restart.
- R4: The image is taken as compressed when bit 1 of header word 229 is 0.
- R5: `ratio_vld_o` is 0 up to and including the cycle in which word 229 is accepted, and 1 from the next cycle. After that, `ratio_vld_o` and `ratio_o` hold their values until the next `sof_i`.
- R6: Codes are 0 = x1, 1 = x2, 2 = x4, 3 = x8. An image that is neither encrypted nor compressed gives code 0 at either width.
- R7: With `wide_i` = 0 (16-bit), a compressed image gives code 2 whether or not it is encrypted, and an image that is encrypted but not compressed gives code 1.
- R8: With `wide_i` = 1 (32-bit), each non-x1 result is one code higher than at 16-bit: compressed gives 3 and encrypted-only gives 2. `wide_i` is sampled only in the cycle word 229 is accepted, and later changes do not alter the held code.
- R9: `eof_i` high in a cycle in which no result is held yet and word 229 is not accepted sets `short_err_o` from the next cycle. The flag stays set until `sof_i`, and while it is set, incoming words are ignored and `ratio_vld_o` stays 0. `eof_i` in the cycle word 229 is accepted, or later, raises no error.
- R10: The word counter saturates after word 229. Words that follow it are ignored, whatever bits they carry.
- R11: A cycle with `word_vld_i` low is not counted, so gaps in the stream do not shift word positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-image pulse; restarts counting |
| eof_i | input | 1 | End-of-image pulse |
| word_vld_i | input | 1 | Stream word valid |
| word_i | input | 32 | Stream word |
| wide_i | input | 1 | Configuration width select: 1 = 32-bit, 0 = 16-bit |
| ratio_o | output | 2 | Clock-to-data ratio code |
| ratio_vld_o | output | 1 | Ratio code is valid |
| short_err_o | output | 1 | Image ended before the compression word |

## Verification
The bench builds the block with its default parameters: 32-bit words, the encryption field at bits [3:2] of word 69, and the compression flag at bit 1 of word 229. It therefore drives full-length headers, and the saturation, late-end and short-image corners all come up at the real word positions. Random images vary the encryption field over all four values, the compression bit, the width and the idle gaps. Directed images cover:
- an end pulse landing exactly on word 229,
- a restart in the middle of an image,
- width changes after the result is held,
- words arriving after an error.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  // Compression dominates encryption; the wide bus doubles any non-unity ratio.
  function automatic ratio_e ratio_of(input logic enc, input logic cmp, input logic wide);
    logic [1:0] base;
    if (!enc && !cmp) begin
      return RATIO_X1;
    end
    base = cmp ? 2'd2 : 2'd1;
    return ratio_e'(base + {1'b0, wide});
  endfunction

endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
  parameter int LAST_IDX = 229,
  parameter int CNT_W    = $clog2(LAST_IDX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic             word_vld_i,
  input  logic             halt_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] idx_o
);

  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(LAST_IDX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx_eff;

  always_comb begin
    idx_eff  = sof_i ? '0 : cnt_q;
    accept_o = word_vld_i && (sof_i || !halt_i) && (idx_eff != SAT_VAL);
    idx_o    = idx_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (accept_o) begin
      cnt_q <= idx_eff + 1'b1;
    end else if (sof_i) begin
      cnt_q <= '0;
    end
  end

  assert_cnt_saturates_R10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= SAT_VAL);

  assert_gap_not_counted_R11: assert property (@(posedge clk) disable iff (rst)
    (!word_vld_i && !sof_i) |=> $stable(cnt_q));

endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1,
  parameter int CNT_W   = $clog2(CMP_IDX + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              accept_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              enc_o,
  output logic              cmp_hit_o,
  output logic              cmp_now_o
);

  logic enc_hit;
  logic enc_q;

  always_comb begin
    enc_hit   = accept_i && (idx_i == CNT_W'(ENC_IDX));
    cmp_hit_o = accept_i && (idx_i == CNT_W'(CMP_IDX));
    cmp_now_o = ~word_i[CMP_BIT];
    enc_o     = enc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_q <= 1'b0;
    end else if (enc_hit) begin
      enc_q <= |word_i[ENC_LSB +: ENC_W];
    end else if (sof_i) begin
      enc_q <= 1'b0;
    end
  end

  assert_enc_changes_on_event_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(enc_q) |-> ($past(sof_i) || $past(enc_hit)));

endmodule

// File: rtl/hdr_ratio_reg.sv
module hdr_ratio_reg
  import cfg_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sof_i,
  input  logic       cmp_hit_i,
  input  logic       enc_i,
  input  logic       cmp_now_i,
  input  logic       wide_i,
  output logic [1:0] ratio_o,
  output logic       vld_o
);

  ratio_e ratio_q;
  logic   vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= RATIO_X1;
      vld_q   <= 1'b0;
    end else if (cmp_hit_i) begin
      ratio_q <= ratio_of(enc_i, cmp_now_i, wide_i);
      vld_q   <= 1'b1;
    end else if (sof_i) begin
      ratio_q <= RATIO_X1;
      vld_q   <= 1'b0;
    end
  end

  assign ratio_o = ratio_q;
  assign vld_o   = vld_q;

  assert_vld_rises_after_hit_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(vld_q) |-> $past(cmp_hit_i));

  assert_result_held_R5: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !sof_i) |=> (vld_q && $stable(ratio_q)));

  assert_plain_is_x1_R6: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit_i && !enc_i && !cmp_now_i) |=> (ratio_q == RATIO_X1));

endmodule

// File: rtl/cfg_hdr_ratio_detect.sv
module cfg_hdr_ratio_detect #(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              word_vld_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              wide_i,
  output logic [1:0]        ratio_o,
  output logic              ratio_vld_o,
  output logic              short_err_o
);

  localparam int CNT_W = $clog2(CMP_IDX + 2);

  logic             accept;
  logic [CNT_W-1:0] idx;
  logic             enc_flag;
  logic             cmp_hit;
  logic             cmp_now;
  logic             err_q;
  logic             vld_int;

  hdr_word_counter #(
    .LAST_IDX (CMP_IDX),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .sof_i      (sof_i),
    .word_vld_i (word_vld_i),
    .halt_i     (err_q),
    .accept_o   (accept),
    .idx_o      (idx)
  );

  hdr_flag_capture #(
    .DATA_W  (DATA_W),
    .ENC_IDX (ENC_IDX),
    .CMP_IDX (CMP_IDX),
    .ENC_LSB (ENC_LSB),
    .ENC_W   (ENC_W),
    .CMP_BIT (CMP_BIT),
    .CNT_W   (CNT_W)
  ) u_flags (
    .clk       (clk),
    .rst       (rst),
    .sof_i     (sof_i),
    .accept_i  (accept),
    .idx_i     (idx),
    .word_i    (word_i),
    .enc_o     (enc_flag),
    .cmp_hit_o (cmp_hit),
    .cmp_now_o (cmp_now)
  );

  hdr_ratio_reg u_ratio (
    .clk       (clk),
    .rst       (rst),
    .sof_i     (sof_i),
    .cmp_hit_i (cmp_hit),
    .enc_i     (enc_flag),
    .cmp_now_i (cmp_now),
    .wide_i    (wide_i),
    .ratio_o   (ratio_o),
    .vld_o     (vld_int)
  );

  // Short-header flag: sticky until the next start pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (sof_i) begin
      err_q <= eof_i && !cmp_hit;
    end else if (eof_i && !vld_int && !cmp_hit) begin
      err_q <= 1'b1;
    end
  end

  assign ratio_vld_o = vld_int;
  assign short_err_o = err_q;

  assert_sof_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (sof_i && !eof_i) |=> (!short_err_o && !ratio_vld_o));

  assert_err_excludes_vld_R9: assert property (@(posedge clk) disable iff (rst)
    !(short_err_o && ratio_vld_o));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (short_err_o && !sof_i) |=> short_err_o);

  assert_no_accept_in_error_R9: assert property (@(posedge clk) disable iff (rst)
    (short_err_o && !sof_i) |-> !accept);

endmodule

// File: tb/cfg_hdr_ratio_detect_tb_top.sv
module cfg_hdr_ratio_detect_tb_top;

  localparam int ENC_POS = 69;
  localparam int CMP_POS = 229;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof = 1'b0;
  logic        eof = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] word = '0;
  logic        wide = 1'b0;
  logic [1:0]  ratio;
  logic        ratio_vld;
  logic        short_err;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  cfg_hdr_ratio_detect dut_i (
    .clk         (clk),
    .rst         (rst),
    .sof_i       (sof),
    .eof_i       (eof),
    .word_vld_i  (vld),
    .word_i      (word),
    .wide_i      (wide),
    .ratio_o     (ratio),
    .ratio_vld_o (ratio_vld),
    .short_err_o (short_err)
  );

  function automatic int exp_code(input logic [1:0] encf, input logic cmpb, input logic w);
    logic e;
    logic c;
    e = (encf != 2'b00);
    c = (cmpb == 1'b0);
    if (!e && !c) return 0;
    if (w) return c ? 3 : 2;
    return c ? 2 : 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Sends n words starting with a sof pulse; leaves inputs idle at the negedge after the last edge.
  task automatic send_image(input int n, input logic [1:0] encf, input logic cmpb,
                            input logic w, input bit gaps, input bit eof_last);
    for (int i = 0; i < n; i++) begin
      if (gaps && i > 0 && ($urandom % 4 == 0)) begin
        @(negedge clk);
        sof = 0; eof = 0; vld = 0; word = $urandom;
      end
      @(negedge clk);
      if (i == CMP_POS) chk("R5 vld low before word 229 edge", int'(ratio_vld), 0);
      sof  = (i == 0);
      eof  = eof_last && (i == n - 1);
      vld  = 1;
      wide = w;
      word = $urandom;
      if (i == ENC_POS) word[3:2] = encf;
      if (i == CMP_POS) word[1] = cmpb;
    end
    @(negedge clk);
    sof = 0; eof = 0; vld = 0;
  endtask

  task automatic pulse_eof();
    @(negedge clk);
    eof = 1;
    @(negedge clk);
    eof = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset vld", int'(ratio_vld), 0);
    chk("R1 reset err", int'(short_err), 0);
    chk("R1 reset ratio", int'(ratio), 0);

    // Directed: every flag combination at both widths.
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 4; k++) begin
        logic [1:0] ef;
        logic cb;
        ef = (k[0]) ? 2'b10 : 2'b00;
        cb = k[1] ? 1'b0 : 1'b1;
        send_image(CMP_POS + 1, ef, cb, w[0], 0, 0);
        chk("R5 vld after word 229", int'(ratio_vld), 1);
        chk(w ? "R8 wide ratio R3 R4 R6" : "R7 narrow ratio R3 R4 R6",
            int'(ratio), exp_code(ef, cb, w[0]));
      end
    end

    // R10: trailing words with flipped flag bits, R8: width change after result.
    send_image(CMP_POS + 1, 2'b01, 1'b1, 1'b0, 0, 0);
    chk("R3 enc field 01", int'(ratio), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      vld = 1; word = 32'h0; wide = 1;
    end
    @(negedge clk);
    vld = 0;
    @(negedge clk);
    chk("R10 trailing words ignored", int'(ratio), 1);
    chk("R8 wide change after result", int'(ratio_vld), 1);

    // R9: short image.
    send_image(100, 2'b11, 1'b0, 1'b1, 0, 0);
    pulse_eof();
    chk("R9 short err set", int'(short_err), 1);
    chk("R9 no vld on short", int'(ratio_vld), 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      vld = 1; word = 32'h0;
    end
    @(negedge clk);
    vld = 0;
    @(negedge clk);
    chk("R9 words ignored after error", int'(ratio_vld), 0);
    chk("R9 err sticky", int'(short_err), 1);

    // R9: eof on the word 229 cycle is not an error; R2 clears the old error.
    send_image(CMP_POS + 1, 2'b00, 1'b0, 1'b0, 0, 1);
    chk("R9 eof on last word no err", int'(short_err), 0);
    chk("R9 eof on last word vld", int'(ratio_vld), 1);
    chk("R7 compressed only narrow", int'(ratio), 2);
    pulse_eof();
    chk("R9 eof after done no err", int'(short_err), 0);

    // R2: restart mid-image discards the earlier encryption flag.
    send_image(150, 2'b11, 1'b1, 1'b0, 0, 0);
    send_image(CMP_POS + 1, 2'b00, 1'b1, 1'b1, 0, 0);
    chk("R2 restart discards enc", int'(ratio), 0);
    chk("R2 restart vld", int'(ratio_vld), 1);
    @(negedge clk);
    sof = 1;
    @(negedge clk);
    sof = 0;
    chk("R2 sof clears vld", int'(ratio_vld), 0);

    // Random images with gaps.
    for (int n = 0; n < 14; n++) begin
      logic [1:0] ef;
      logic cb;
      logic wr;
      ef = 2'($urandom);
      cb = 1'($urandom);
      wr = 1'($urandom);
      send_image(CMP_POS + 1, ef, cb, wr, 1, 0);
      chk("R11 gaps vld", int'(ratio_vld), 1);
      chk("R11 gaps ratio", int'(ratio), exp_code(ef, cb, wr));
    end

    finish_run();
  end

endmodule